// File: doc/BRIEF.md
# Burst Address Counter Register

This block produces the word address that one port of a synchronous memory uses in each clock cycle. Three active-low controls, sampled on the port clock, pick the address: a counter clear forces address zero, an address strobe passes the external address through, a count enable steps the stored address up by one, and with none of them asserted the stored address is reused. The address chosen for a cycle is presented combinationally in that same cycle and is captured into the counter register on the rising edge, so the next cycle continues from it.

Clear beats strobe, and strobe beats count enable. Neither a clear nor a load costs an idle cycle: the access that uses the new address happens in the cycle the control is asserted. The counter covers the full address space and rolls over from the highest address to zero. The address width is a parameter, normally 12 or 13 bits, and a synchronous active-high system reset empties the counter.

Top module: `burst_addr_counter`

## Requirements
- R1: While `cntRstN` is 0, `accessAddr` is 0 in that cycle whatever `adsN`, `cntEnN` and `extAddr` are, and the counter holds 0 afterwards.
- R2: While `cntRstN` is 1 and `adsN` is 0, `accessAddr` equals `extAddr` in that cycle, and that value is stored in the counter.
- R3: While `cntRstN` and `adsN` are 1 and `cntEnN` is 0, `accessAddr` is one more than the address used in the previous cycle.
- R4: While `cntRstN`, `adsN` and `cntEnN` are all 1, `accessAddr` repeats the previous cycle's address and `extAddr` has no effect on it.
- R5: Stepping from the all-ones address yields address 0.
- R6: After `sysRst` (active high, synchronous) is released, a cycle with no control asserted uses address 0.
- R7: `cntEnN` has no effect while `cntRstN` or `adsN` is 0.
- R8: The parameter `AW` sets the address width; at 13 bits the counter behaves as above across the full 13-bit range, rolling over from 13'h1FFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| sysRst | input | 1 | Synchronous active-high reset of the counter |
| extAddr | input | AW | External address |
| adsN | input | 1 | Active-low address strobe (load) |
| cntEnN | input | 1 | Active-low count enable (advance) |
| cntRstN | input | 1 | Active-low counter clear |
| accessAddr | output | AW | Address used for the access in the current cycle |

## Verification
Clear, load and advance can all be requested in one cycle, and the block must honour only the highest one. The bench drives every combination of the three controls, both in directed steps that assert a strobe or clear together with count enable and in a long run of random control patterns with random addresses. Each cycle the output is compared with a behavioural model that applies the priority order and the roll-over, so a wrong priority or a lost increment shows up as a mismatch in the very cycle it happens.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  // Decoded, mutually exclusive counter actions.
  typedef struct packed {
    logic clear;
    logic load;
    logic advance;
  } ctlStrobes_t;
endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic        adsN,
  input  logic        cntEnN,
  input  logic        cntRstN,
  output ctlStrobes_t strobes
);
  // Priority: clear over load over advance.
  always_comb begin
    strobes = '0;
    if (!cntRstN)     strobes.clear   = 1'b1;
    else if (!adsN)   strobes.load    = 1'b1;
    else if (!cntEnN) strobes.advance = 1'b1;
  end
endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          sysRst,
  input  ctlStrobes_t   strobes,
  input  logic [AW-1:0] extAddr,
  output logic [AW-1:0] accessAddr
);
  localparam logic [AW-1:0] ZERO_ADDR = '0;
  localparam logic [AW-1:0] ONE_STEP  = AW'(1);

  logic [AW-1:0] countReg;
  logic [AW-1:0] stepped;

  // Natural truncation gives the roll-over from all ones to zero.
  assign stepped = countReg + ONE_STEP;

  always_comb begin
    if (strobes.clear)        accessAddr = ZERO_ADDR;
    else if (strobes.load)    accessAddr = extAddr;
    else if (strobes.advance) accessAddr = stepped;
    else                      accessAddr = countReg;
  end

  always_ff @(posedge clk) begin
    if (sysRst) countReg <= ZERO_ADDR;
    else        countReg <= accessAddr;
  end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import burst_addr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          sysRst,
  input  logic [AW-1:0] extAddr,
  input  logic          adsN,
  input  logic          cntEnN,
  input  logic          cntRstN,
  output logic [AW-1:0] accessAddr
);
  ctlStrobes_t strobes;

  burst_addr_ctrl uCtrl (
    .adsN    (adsN),
    .cntEnN  (cntEnN),
    .cntRstN (cntRstN),
    .strobes (strobes)
  );

  burst_addr_dp #(.AW(AW)) uDp (
    .clk        (clk),
    .sysRst     (sysRst),
    .strobes    (strobes),
    .extAddr    (extAddr),
    .accessAddr (accessAddr)
  );
endmodule

// File: rtl/burst_addr_checker.sv
module burst_addr_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          sysRst,
  input logic [AW-1:0] extAddr,
  input logic          adsN,
  input logic          cntEnN,
  input logic          cntRstN,
  input logic [AW-1:0] accessAddr
);
  // Set once a full non-reset cycle has passed, so $past refers to a stored address.
  logic seenEdge;
  always_ff @(posedge clk) begin
    if (sysRst) seenEdge <= 1'b0;
    else        seenEdge <= 1'b1;
  end

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (sysRst)
    !cntRstN |-> accessAddr == '0);

  assert_load_pass_R2: assert property (@(posedge clk) disable iff (sysRst)
    (cntRstN && !adsN) |-> accessAddr == extAddr);

  // Also covers the roll-over of R5 through the width cast.
  assert_advance_step_R3: assert property (@(posedge clk) disable iff (sysRst)
    (seenEdge && cntRstN && adsN && !cntEnN) |-> accessAddr == AW'($past(accessAddr) + 1));

  assert_hold_still_R4: assert property (@(posedge clk) disable iff (sysRst)
    (seenEdge && cntRstN && adsN && cntEnN) |-> accessAddr == $past(accessAddr));

  assert_init_zero_R6: assert property (@(posedge clk) disable iff (sysRst)
    ($fell(sysRst) && cntRstN && adsN && cntEnN) |-> accessAddr == '0);
endmodule

bind burst_addr_counter burst_addr_checker #(.AW(AW)) uChk (
  .clk        (clk),
  .sysRst     (sysRst),
  .extAddr    (extAddr),
  .adsN       (adsN),
  .cntEnN     (cntEnN),
  .cntRstN    (cntRstN),
  .accessAddr (accessAddr)
);

// File: tb/burst_addr_counter_test.sv
module burst_addr_counter_test;
  logic        clk = 1'b0;
  logic        sysRst = 1'b1;
  logic [12:0] extAddr = '0;
  logic        adsN = 1'b1, cntEnN = 1'b1, cntRstN = 1'b1;
  logic [11:0] accessAddr;
  logic [12:0] accessAddr13;

  int checks = 0;
  int errors = 0;
  int ref12 = 0;
  int ref13 = 0;

  always #4 clk = ~clk;

  burst_addr_counter #(.AW(12)) uut (
    .clk(clk), .sysRst(sysRst), .extAddr(extAddr[11:0]),
    .adsN(adsN), .cntEnN(cntEnN), .cntRstN(cntRstN), .accessAddr(accessAddr)
  );

  burst_addr_counter #(.AW(13)) uut13 (
    .clk(clk), .sysRst(sysRst), .extAddr(extAddr),
    .adsN(adsN), .cntEnN(cntEnN), .cntRstN(cntRstN), .accessAddr(accessAddr13)
  );

  // Behavioural expectation for one cycle at a given width.
  function automatic int model(int prev, int width, bit rst, bit ads, bit en, int ext);
    int span = 1 << width;
    if (rst)      return 0;
    else if (!cntRstN) return 0;
    else if (!adsN) return ext % span;
    else if (!cntEnN) return (prev + 1) % span;
    return prev;
  endfunction

  task automatic step(bit rst, bit aN, bit eN, bit cN, int addr, string req);
    int exp12, exp13;
    string tag;
    @(negedge clk);
    sysRst = rst; adsN = aN; cntEnN = eN; cntRstN = cN; extAddr = 13'(addr);
    #1;
    if (!cN) tag = "R1";
    else if (!aN) tag = "R2";
    else if (!eN) tag = "R3";
    else tag = "R4";
    if (req != "") tag = req;
    exp12 = model(ref12, 12, 1'b0, aN, eN, addr);
    exp13 = model(ref13, 13, 1'b0, aN, eN, addr);
    if (!rst) begin
      checks++;
      if (int'(accessAddr) != exp12) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", tag, accessAddr, exp12);
      end
      checks++;
      if (int'(accessAddr13) != exp13) begin
        errors++;
        $display("FAIL R8 (%s) actual=%h expected=%h", tag, accessAddr13, exp13);
      end
    end
    @(posedge clk);
    ref12 = rst ? 0 : exp12;
    ref13 = rst ? 0 : exp13;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ref12 = 5; ref13 = 5;
    step(1, 1, 1, 1, 13'h0abc, "R6");
    step(1, 0, 0, 1, 13'h0abc, "R6");
    step(0, 1, 1, 1, 13'h1555, "R6");  // after reset: address 0
    step(0, 0, 1, 1, 13'h0123, "R2");  // load
    step(0, 1, 0, 1, 13'h0000, "R3");  // 124
    step(0, 1, 0, 1, 13'h0000, "R3");  // 125
    step(0, 1, 1, 1, 13'h1f0f, "R4");  // hold, ext ignored
    step(0, 1, 1, 1, 13'h0001, "R4");
    step(0, 0, 0, 1, 13'h0040, "R7");  // load wins over advance
    step(0, 1, 1, 1, 13'h0000, "R7");  // stays 040
    step(0, 0, 0, 0, 13'h0777, "R7");  // clear wins over both
    step(0, 1, 0, 0, 13'h0777, "R1");  // clear wins over advance
    step(0, 0, 1, 0, 13'h0777, "R1");  // clear wins over load
    step(0, 1, 0, 1, 13'h0000, "R1");  // continues from 0 -> 1
    step(0, 0, 1, 1, 13'h0ffe, "R5");
    step(0, 1, 0, 1, 13'h0000, "R5");  // fff (12b), 0fff (13b)
    step(0, 1, 0, 1, 13'h0000, "R5");  // 000 (12b), 1000 (13b)
    step(0, 1, 0, 1, 13'h0000, "R5");
    step(0, 0, 1, 1, 13'h1ffe, "R8");
    step(0, 1, 0, 1, 13'h0000, "R8");  // 13b: 1fff
    step(0, 1, 0, 1, 13'h0000, "R8");  // 13b: 0000
    step(0, 1, 1, 1, 13'h1234, "R8");
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      step(r == 0, ($urandom & 1) == 0 ? 1'b0 : 1'b1, ($urandom % 4) == 0 ? 1'b1 : 1'b0,
           ($urandom % 10) == 0 ? 1'b0 : 1'b1, int'($urandom % 8192), "");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule